// File: doc/BRIEF.md
# Smart Card Character Transmitter with Automatic Resend

This block sends characters over a single open-drain wire of the kind smart-card links use. A CPU writes a byte into a holding register. At the next bit-rate tick the byte moves into a shift register, and the block sends one frame: a low start bit, the eight data bits starting with the least significant, and an even parity bit. The block then lets go of the wire for two bit times. In the first of these, the receiving side may pull the wire low to report that the character was corrupted. The block samples that slot once, at mid-bit.

When the receiver reports an error, the block sets a sticky error flag and sends the same byte again straight away, with no CPU action. The completion flag and the empty flag stay low until a frame goes through clean. They then rise together, and so software sees exactly one completion per byte however many resends it took. A byte written while a frame is on the wire waits in the holding register and goes out with no gap when the current character completes. Two level interrupt requests are formed from the flags and their enables. Reception, the card clock and the bit-rate divider belong to other blocks; this block only counts `bit_tick_i` pulses, `SPB` of them per bit.

Top module: `sc_tx_top`

## Requirements
- R1: A frame starts on a tick edge. Each bit lasts `SPB` ticks. The bits are sent in this order: start bit (low), then data bits 0 to 7 with the least significant bit first. `sd_drive_low_o` is 1 exactly when the bit being sent is 0.
- R2: Bit slot 9 carries even parity: `sd_drive_low_o` equals the inverse of the XOR of the eight data bits.
- R3: In bit slots 10 and 11 the line is released (`sd_drive_low_o` = 0). `sd_i` is sampled once, on the tick edge that ends sub-tick `SPB/2` of slot 10. The next frame or resend starts exactly `12*SPB` tick edges after the current frame started.
- R4: If a frame ends with no error seen and no byte is waiting, `tend_o` and `tdre_o` both rise to 1 on the closing tick edge, `sd_drive_low_o` stays 0, and `err_o` is left unchanged.
- R5: `txi_o` is `tend_o` AND `tx_ie_i`.
- R6: If `sd_i` is low at the sample point, the same byte is sent again, starting on the closing tick edge. `tend_o` and `tdre_o` stay 0 from frame start until a clean completion.
- R7: `err_o` is set by a detected error signal and is never cleared by hardware. A status write (`wr_sel_i` = 1) with `wr_data_i[0]` = 0 clears it. A status write with bit 0 = 1 leaves it unchanged. `eri_o` is `err_o` AND `err_ie_i`.
- R8: A data write (`wr_sel_i` = 0) clears `tdre_o` and `tend_o`. If the block is idle, the frame starts on the next tick edge after the write. If a frame is in progress, the byte is held and its frame starts on the closing tick edge of the current clean frame.
- R9: After reset, `tdre_o` = `tend_o` = 1, `err_o` = 0 and the line is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bit_tick_i | input | 1 | Bit-rate enable, `SPB` pulses per bit |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 1 | 0 = data register, 1 = status register |
| wr_data_i | input | DATA_W | Write data; bit 0 is the error-flag clear for status writes |
| tx_ie_i | input | 1 | Completion interrupt enable |
| err_ie_i | input | 1 | Error interrupt enable |
| sd_i | input | 1 | Sensed level of the shared data wire |
| sd_drive_low_o | output | 1 | Open-drain pull-down enable for the data wire |
| tdre_o | output | 1 | Data register empty |
| tend_o | output | 1 | Transmission end |
| err_o | output | 1 | Error signal seen (sticky) |
| txi_o | output | 1 | Completion interrupt request |
| eri_o | output | 1 | Error interrupt request |

## Verification
The bench counts tick edges itself and takes the tick edge that starts a frame as position 0. Each bit is sampled at sub-tick 2 of its slot. The card's error pull covers tick edge `10*SPB+3`, and the error flag is read after that edge. The resend, the back-to-back start or the flag rise is checked right after edge `12*SPB`. A register write takes effect on the next clock edge. An idle frame is expected to start on the first tick edge after that write, so the bench reads flags one clock after each write and compares the observed start edge with the write's tick count plus one. All 256 byte values are sent with zero, one or two forced resends, and the interrupt enables change from byte to byte.

// File: rtl/sc_tx_pkg.sv
package sc_tx_pkg;
  typedef enum logic {
    S_IDLE  = 1'b0,
    S_FRAME = 1'b1
  } tx_state_e;
endpackage

// File: rtl/sc_tx_parity.sv
module sc_tx_parity #(
  parameter int DATA_W = 8,
  parameter bit ODD    = 1'b0
) (
  input  logic [DATA_W-1:0] data_i,
  output logic              par_o
);
  assign par_o = (^data_i) ^ ODD;
endmodule

// File: rtl/sc_tx_regs.sv
module sc_tx_regs #(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic              wr_sel_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              load_i,
  input  logic              err_hit_i,
  output logic [DATA_W-1:0] tdr_o,
  output logic              pend_o,
  output logic              err_o
);
  logic data_wr, err_clr;

  assign data_wr = wr_en_i && !wr_sel_i;
  assign err_clr = wr_en_i && wr_sel_i && !wr_data_i[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tdr_o  <= '0;
      pend_o <= 1'b0;
    end else if (data_wr) begin
      tdr_o  <= wr_data_i;
      pend_o <= 1'b1;
    end else if (load_i) begin
      pend_o <= 1'b0;
    end
  end

  // hardware set wins over software clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        err_o <= 1'b0;
    else if (err_hit_i) err_o <= 1'b1;
    else if (err_clr)   err_o <= 1'b0;
  end
endmodule

// File: rtl/sc_tx_frame.sv
module sc_tx_frame
  import sc_tx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int SPB    = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              pend_i,
  input  logic [DATA_W-1:0] tdr_i,
  input  logic              sd_i,
  output logic              load_o,
  output logic              active_o,
  output logic              err_hit_o,
  output logic              drive_low_o
);
  localparam int NSLOT = DATA_W + 4;
  localparam int SW    = $clog2(NSLOT);
  localparam int UW    = (SPB > 1) ? $clog2(SPB) : 1;
  localparam logic [SW-1:0] LAST_DATA = SW'(DATA_W);
  localparam logic [SW-1:0] PAR_SLOT  = SW'(DATA_W + 1);
  localparam logic [SW-1:0] ERR_SLOT  = SW'(DATA_W + 2);
  localparam logic [SW-1:0] LAST_SLOT = SW'(DATA_W + 3);
  localparam logic [UW-1:0] MID_SUB   = UW'(SPB / 2);
  localparam logic [UW-1:0] LAST_SUB  = UW'(SPB - 1);

  tx_state_e         state_q;
  logic [SW-1:0]     slot_q;
  logic [UW-1:0]     sub_q;
  logic [DATA_W-1:0] tsr_q;
  logic [DATA_W-1:0] tsr_shift;
  logic              err_seen_q;
  logic              par;
  logic              bit_end, frame_end, retry;

  sc_tx_parity #(.DATA_W(DATA_W), .ODD(1'b0)) u_par (
    .data_i (tsr_q),
    .par_o  (par)
  );

  assign bit_end   = tick_i && (sub_q == LAST_SUB);
  assign frame_end = (state_q == S_FRAME) && bit_end && (slot_q == LAST_SLOT);
  assign retry     = frame_end && err_seen_q;
  assign load_o    = tick_i && pend_i &&
                     ((state_q == S_IDLE) || (frame_end && !err_seen_q));
  assign err_hit_o = (state_q == S_FRAME) && tick_i && (slot_q == ERR_SLOT) &&
                     (sub_q == MID_SUB) && !sd_i;
  assign active_o  = (state_q == S_FRAME);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= S_IDLE;
      slot_q     <= '0;
      sub_q      <= '0;
      tsr_q      <= '0;
      err_seen_q <= 1'b0;
    end else if (load_o) begin
      state_q    <= S_FRAME;
      slot_q     <= '0;
      sub_q      <= '0;
      tsr_q      <= tdr_i;
      err_seen_q <= 1'b0;
    end else if (retry) begin
      slot_q     <= '0;
      sub_q      <= '0;
      err_seen_q <= 1'b0;
    end else if (frame_end) begin
      state_q    <= S_IDLE;
    end else if ((state_q == S_FRAME) && tick_i) begin
      if (bit_end) begin
        sub_q  <= '0;
        slot_q <= slot_q + SW'(1);
      end else begin
        sub_q  <= sub_q + UW'(1);
      end
      if (err_hit_o) err_seen_q <= 1'b1;
    end
  end

  assign tsr_shift = tsr_q >> (slot_q - SW'(1));

  always_comb begin
    drive_low_o = 1'b0;
    if (state_q == S_FRAME) begin
      if (slot_q == '0)             drive_low_o = 1'b1;
      else if (slot_q <= LAST_DATA) drive_low_o = ~tsr_shift[0];
      else if (slot_q == PAR_SLOT)  drive_low_o = ~par;
    end
  end
endmodule

// File: rtl/sc_tx_top.sv
module sc_tx_top #(
  parameter int DATA_W = 8,
  parameter int SPB    = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bit_tick_i,
  input  logic              wr_en_i,
  input  logic              wr_sel_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              tx_ie_i,
  input  logic              err_ie_i,
  input  logic              sd_i,
  output logic              sd_drive_low_o,
  output logic              tdre_o,
  output logic              tend_o,
  output logic              err_o,
  output logic              txi_o,
  output logic              eri_o
);
  logic [DATA_W-1:0] tdr;
  logic pend, load, active, err_hit;

  sc_tx_regs #(.DATA_W(DATA_W)) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .wr_sel_i  (wr_sel_i),
    .wr_data_i (wr_data_i),
    .load_i    (load),
    .err_hit_i (err_hit),
    .tdr_o     (tdr),
    .pend_o    (pend),
    .err_o     (err_o)
  );

  sc_tx_frame #(.DATA_W(DATA_W), .SPB(SPB)) u_frame (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .tick_i      (bit_tick_i),
    .pend_i      (pend),
    .tdr_i       (tdr),
    .sd_i        (sd_i),
    .load_o      (load),
    .active_o    (active),
    .err_hit_o   (err_hit),
    .drive_low_o (sd_drive_low_o)
  );

  // completion and empty share one condition: nothing waiting, nothing on the wire
  assign tdre_o = !pend && !active;
  assign tend_o = !pend && !active;
  assign txi_o  = tend_o && tx_ie_i;
  assign eri_o  = err_o && err_ie_i;
endmodule

// File: rtl/sc_tx_chk.sv
module sc_tx_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_en_i,
  input logic              wr_sel_i,
  input logic [DATA_W-1:0] wr_data_i,
  input logic              load,
  input logic              active,
  input logic              err_hit,
  input logic              sd_drive_low_o,
  input logic              tdre_o,
  input logic              tend_o,
  input logic              err_o
);
  AST_START_BIT_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load |=> sd_drive_low_o) else $error("start bit not driven"); // R1
  AST_LOAD_CLEARS_EMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load |=> (active && !tdre_o)) else $error("load left empty set"); // R8
  AST_TEND_LOW_IN_FRAME: assert property (@(posedge clk_i) disable iff (!rst_ni)
    active |-> !tend_o) else $error("tend high in frame"); // R6
  AST_IDLE_RELEASED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !active |-> !sd_drive_low_o) else $error("line driven while idle"); // R3
  AST_ERR_SETS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_hit |=> err_o) else $error("error not flagged"); // R7
  AST_ERR_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_o && !(wr_en_i && wr_sel_i && !wr_data_i[0])) |=> err_o)
    else $error("error flag cleared by hardware"); // R7
  AST_CLEAN_END_FLAGS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(active) |-> (tend_o && tdre_o)) else $error("flags not raised at end"); // R4
endmodule

bind sc_tx_top sc_tx_chk #(.DATA_W(DATA_W)) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .wr_en_i        (wr_en_i),
  .wr_sel_i       (wr_sel_i),
  .wr_data_i      (wr_data_i),
  .load           (load),
  .active         (active),
  .err_hit        (err_hit),
  .sd_drive_low_o (sd_drive_low_o),
  .tdre_o         (tdre_o),
  .tend_o         (tend_o),
  .err_o          (err_o)
);

// File: tb/sc_tx_top_test.sv
`timescale 1ns/1ps
module sc_tx_top_test;
  localparam int DW  = 8;
  localparam int SPB = 4;
  localparam int FRAME_T = 12 * SPB;

  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0;
  logic wr_en = 1'b0, wr_sel = 1'b0;
  logic [DW-1:0] wr_data = '0;
  logic tx_ie = 1'b1, err_ie = 1'b0, card_pull = 1'b0;
  logic sd, drv, tdre, tend, err, txi, eri;
  int n_chk = 0, n_fail = 0;
  int tick_cnt = 0;
  bit err_exp = 1'b0;

  always #5 clk = ~clk;
  assign sd = !(drv || card_pull);

  sc_tx_top #(.DATA_W(DW), .SPB(SPB)) uut (
    .clk_i (clk), .rst_ni (rst_n), .bit_tick_i (tick),
    .wr_en_i (wr_en), .wr_sel_i (wr_sel), .wr_data_i (wr_data),
    .tx_ie_i (tx_ie), .err_ie_i (err_ie), .sd_i (sd),
    .sd_drive_low_o (drv), .tdre_o (tdre), .tend_o (tend),
    .err_o (err), .txi_o (txi), .eri_o (eri)
  );

  initial forever begin
    @(negedge clk);
    tick = rst_n ? ~tick : 1'b0;
  end

  always @(posedge clk) if (tick) tick_cnt <= tick_cnt + 1;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic at_pos(input int base, input int p);
    while (tick_cnt < base + p) @(negedge clk);
  endtask

  task automatic wr(input bit sel, input logic [DW-1:0] d);
    wr_sel = sel; wr_data = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // one frame from its start edge; mid_wr writes nxt during the frame
  task automatic frame(input int base, input logic [DW-1:0] b, input bit pull,
                       input bit mid_wr, input logic [DW-1:0] nxt);
    at_pos(base, 2);
    chk(drv == 1'b1, "R1 start", drv, 1);
    chk(!tend && !tdre, "R6 flags low", {tend, tdre}, 0);
    for (int k = 1; k <= DW; k++) begin
      at_pos(base, k * SPB + 2);
      chk(drv == !b[k-1], "R1 data bit", drv, !b[k-1]);
      if (mid_wr && k == 4) begin
        wr(1'b0, nxt);
        chk(!tdre && !tend, "R8 held write", {tdre, tend}, 0);
      end
    end
    at_pos(base, 9 * SPB + 2);
    chk(drv == !(^b), "R2 parity", drv, !(^b));
    at_pos(base, 10 * SPB + 1);
    chk(drv == 1'b0, "R3 err slot released", drv, 0);
    card_pull = pull;
    at_pos(base, 10 * SPB + 3);
    card_pull = 1'b0;
    if (pull) err_exp = 1'b1;
    chk(err == err_exp, "R7 err flag", err, err_exp);
    at_pos(base, 11 * SPB + 2);
    chk(drv == 1'b0, "R3 guard released", drv, 0);
    chk(!tend, "R6 tend low", tend, 0);
    at_pos(base, FRAME_T);
    if (pull) begin
      chk(drv == 1'b1 && !tend, "R6 resend start", {drv, tend}, 2);
    end else if (mid_wr) begin
      chk(drv == 1'b1 && !tdre, "R8 back-to-back", {drv, tdre}, 2);
    end else begin
      chk(drv == 1'b0, "R4 line idle", drv, 0);
      chk(tend && tdre, "R4 flags", {tend, tdre}, 3);
      chk(err == err_exp, "R4 err unchanged", err, err_exp);
      chk(txi == tx_ie, "R5 txi", txi, tx_ie);
    end
  endtask

  task automatic start_idle(input logic [DW-1:0] b, output int base);
    int w, lim;
    wr(1'b0, b);
    w = tick_cnt;
    chk(!tdre && !tend, "R8 write clears", {tdre, tend}, 0);
    lim = 0;
    while (!drv && lim < 20) begin @(negedge clk); lim++; end
    base = tick_cnt;
    chk(base == w + 1, "R8 start delay", base - w, 1);
  endtask

  initial begin
    #2000000;
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    int base;
    repeat (3) @(negedge clk);
    chk(tdre && tend, "R9 flags", {tdre, tend}, 3);
    chk(!err && !drv, "R9 err/line", {err, drv}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(txi == 1'b1 && eri == 1'b0, "R5 reset irq", {txi, eri}, 2);

    for (int v = 0; v < 256; v++) begin
      logic [DW-1:0] b;
      int nres;
      b = DW'(v);
      nres = v % 3;
      tx_ie = b[0];
      err_ie = b[1];
      start_idle(b, base);
      for (int a = 0; a <= nres; a++) begin
        frame(base, b, a < nres, 1'b0, '0);
        base = base + FRAME_T;
      end
      @(negedge clk);
      chk(eri == (err_exp && err_ie), "R7 eri", eri, err_exp && err_ie);
      chk(txi == tx_ie, "R5 txi idle", txi, tx_ie);
      if (err_exp) begin
        wr(1'b1, 8'h01);
        chk(err == 1'b1, "R7 write one ignored", err, 1);
        wr(1'b1, 8'hFE);
        err_exp = 1'b0;
        chk(err == 1'b0, "R7 write zero clears", err, 0);
      end
    end

    // held write during a frame, sent without gap
    tx_ie = 1'b1;
    start_idle(8'h5A, base);
    frame(base, 8'h5A, 1'b0, 1'b1, 8'hC3);
    base = base + FRAME_T;
    frame(base, 8'hC3, 1'b1, 1'b0, '0);
    base = base + FRAME_T;
    frame(base, 8'hC3, 1'b0, 1'b0, '0);
    @(negedge clk);
    wr(1'b1, 8'h00);
    chk(err == 1'b0, "R7 clear", err, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule